// File: doc/BRIEF.md
# Dual-Mode Multiplicity Trigger

This block makes the acquisition trigger for a detector with 64 discriminated, pre-stretched hit lines. It runs in one of two modes, chosen at run time. In autonomous mode it counts how many lines are high in each system-clock bin. It fires when that count is at least a programmable occupancy threshold, so it acts as an N-fold coincidence among any of the lines. In external mode it passes on a trigger that comes from a companion detector, and it ignores the hit lines.

Both paths run through the same pipeline depth, so the trigger latency is the same in either mode. The output is a one-cycle pulse made on the rising edge of the selected condition. The current hit count is also brought out, for monitoring and for testing. The mode select and the threshold are plain ports that may change at any time.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is asserted, and just after it is released, `trigPulse` is 0 and `hitCount` is 0.
- R2: `hitCount` equals the number of `hitLines` bits that were high before the clock edge two edges earlier.
- R3: With `modeAuto`=1 and a nonzero threshold, a line pattern whose count is greater than or equal to `occThresh` gives `trigPulse`=1 in the cycle after the third rising edge following the pattern's application.
- R4: In autonomous mode, a count below `occThresh` produces no pulse.
- R5: `occThresh`=0 disables autonomous triggering entirely, whatever the line pattern.
- R6: With `modeAuto`=0, a rising `extTrig` gives `trigPulse`=1 after the third rising edge (the same latency as R3). The hit lines have no effect on the trigger in this mode.
- R7: With `modeAuto`=1, `extTrig` has no effect on `trigPulse`.
- R8: `trigPulse` is high for exactly one cycle for each rising edge of the selected condition. A condition that stays true gives a single pulse, and a new pulse needs the condition to go false and then true again.
- R9: `modeAuto` is registered. A change applied before edge E steers the condition evaluated at edge E+1. If the newly selected condition is already true while the old one was false, a pulse appears after edge E+1.
- R10: The threshold limits hold exactly: `occThresh`=64 fires only with all 64 lines high (63 lines do not fire), and `occThresh`=1 fires on a single line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one period is one time bin |
| rst_n | input | 1 | Asynchronous active-low reset |
| hitLines | input | 64 | Stretched hit lines, one per channel |
| extTrig | input | 1 | Trigger level from the companion detector |
| modeAuto | input | 1 | 1 = autonomous multiplicity, 0 = external trigger |
| occThresh | input | 7 | Occupancy threshold N; 0 disables autonomous triggering |
| trigPulse | output | 1 | One-cycle trigger pulse |
| hitCount | output | 7 | Number of active lines, two cycles after sampling |

## Verification
A fault in the partial-sum or adder stage shows as a wrong `hitCount` exactly two edges after a pattern is applied. The bench compares against an independent bit count for sparse, dense, alternating and full patterns. A fault in the threshold compare, the delay line or the edge detector shows at `trigPulse` on the third edge. It can appear as a missing pulse, an extra pulse, a pulse one cycle off, or a pulse held too long. For this reason each trigger check samples the cycles just before, at and just after the expected pulse. A fault in the mode register shows as the wrong path being obeyed, one edge later than expected.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Qualified trigger conditions produced by the datapath, consumed by control
  typedef struct packed {
    logic autoHit;  // multiplicity condition met this bin
    logic extHit;   // external trigger, delay-matched to the count pipe
  } trig_flags_t;
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int GRP_SIZE  = 8,
  parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hitLines,
  input  logic                 extTrig,
  input  logic [CNT_W-1:0]     occThresh,
  output logic [CNT_W-1:0]     hitCount,
  output trig_flags_t          flags
);
  localparam int NUM_GRP = NUM_LINES / GRP_SIZE;
  localparam int PW      = $clog2(GRP_SIZE + 1);

  logic [PW-1:0]    partialQ [NUM_GRP];
  logic [CNT_W-1:0] sumNext;
  logic             extD1, extD2;

  // Stage 1: per-group population counts
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [PW-1:0] grpCnt;
    always_comb begin
      grpCnt = '0;
      for (int b = 0; b < GRP_SIZE; b++)
        grpCnt = grpCnt + PW'(hitLines[g*GRP_SIZE + b]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) partialQ[g] <= '0;
      else        partialQ[g] <= grpCnt;
    end
  end

  // Stage 2: sum of group counts
  always_comb begin
    sumNext = '0;
    for (int g = 0; g < NUM_GRP; g++)
      sumNext = sumNext + CNT_W'(partialQ[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitCount <= '0;
      extD1    <= 1'b0;
      extD2    <= 1'b0;
    end else begin
      hitCount <= sumNext;
      extD1    <= extTrig;
      extD2    <= extD1;
    end
  end

  always_comb begin
    flags.autoHit = (occThresh != '0) && (hitCount >= occThresh);
    flags.extHit  = extD2;
  end

  // Checking aid: edges elapsed since reset, saturating at 2
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_count_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (hitCount == CNT_W'($countones($past(hitLines, 2)))));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hitCount <= CNT_W'(NUM_LINES));
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        modeAuto,
  input  trig_flags_t flags,
  output logic        trigPulse
);
  logic modeReg;
  logic condSel;
  logic prevCond;

  assign condSel = modeReg ? flags.autoHit : flags.extHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg   <= 1'b0;
      prevCond  <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      modeReg   <= modeAuto;
      prevCond  <= condSel;
      trigPulse <= condSel && !prevCond;
    end
  end

  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |=> !trigPulse);

  p_auto_ignores_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReg && !flags.autoHit) |=> !trigPulse);
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import trig_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int GRP_SIZE  = 8,
  parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hitLines,
  input  logic                 extTrig,
  input  logic                 modeAuto,
  input  logic [CNT_W-1:0]     occThresh,
  output logic                 trigPulse,
  output logic [CNT_W-1:0]     hitCount
);
  trig_flags_t flags;

  trig_datapath #(
    .NUM_LINES(NUM_LINES),
    .GRP_SIZE (GRP_SIZE),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .hitLines (hitLines),
    .extTrig  (extTrig),
    .occThresh(occThresh),
    .hitCount (hitCount),
    .flags    (flags)
  );

  trig_control u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .modeAuto (modeAuto),
    .flags    (flags),
    .trigPulse(trigPulse)
  );

  // Zero threshold in autonomous mode never lets a pulse out
  p_zero_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    modeAuto |=> (occThresh != '0 || !trigPulse));
endmodule

// File: tb/sim_coinc_trigger.sv
module sim_coinc_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] hitLines = '0;
  logic        extTrig = 1'b0;
  logic        modeAuto = 1'b1;
  logic [6:0]  occThresh = '0;
  logic        trigPulse;
  logic [6:0]  hitCount;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  coinc_trigger u0 (
    .clk(clk), .rst_n(rst_n), .hitLines(hitLines), .extTrig(extTrig),
    .modeAuto(modeAuto), .occThresh(occThresh),
    .trigPulse(trigPulse), .hitCount(hitCount)
  );

  function automatic int ones(input logic [63:0] v);
    int c = 0;
    for (int i = 0; i < 64; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    hitLines = '0;
    extTrig  = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Apply a line pattern at a negedge and check count and pulse timing
  task automatic apply_lines(input logic [63:0] v, input bit expFire, input string req);
    @(negedge clk);
    hitLines = v;
    @(negedge clk);
    check({req, " no early pulse"}, int'(trigPulse), 0);
    @(negedge clk);
    check("R2 count", int'(hitCount), ones(v));
    check({req, " no pulse at edge 2"}, int'(trigPulse), 0);
    @(negedge clk);
    check({req, " pulse at edge 3"}, int'(trigPulse), int'(expFire));
    @(negedge clk);
    check("R8 single cycle", int'(trigPulse), 0);
    idle(4);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", int'(trigPulse), 0);
    check("R1 count in reset", int'(hitCount), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pulse after reset", int'(trigPulse), 0);
    check("R1 count after reset", int'(hitCount), 0);
  endtask

  task automatic t_count_zero_thresh();
    modeAuto = 1'b1; occThresh = 7'd0; idle(3);
    apply_lines(64'h0000_0000_0000_0001, 0, "R5");
    apply_lines(64'hA5A5_A5A5_A5A5_A5A5, 0, "R5");
    apply_lines(64'hFFFF_FFFF_FFFF_FFFF, 0, "R5");
    apply_lines(64'h8000_0100_0000_0010, 0, "R5");
  endtask

  task automatic t_auto_fire();
    occThresh = 7'd5; idle(2);
    apply_lines(64'h0000_1000_0100_0011, 0, "R4");
    apply_lines(64'h0010_1000_0100_0011, 1, "R3");
    // Held condition: one pulse only, then re-arm after drop
    @(negedge clk); hitLines = 64'hFF;
    repeat (3) @(negedge clk);
    check("R8 held first pulse", int'(trigPulse), 1);
    repeat (4) begin
      @(negedge clk);
      check("R8 held no repeat", int'(trigPulse), 0);
    end
    hitLines = '0;
    @(negedge clk); hitLines = 64'hFF;
    repeat (3) @(negedge clk);
    check("R8 re-armed pulse", int'(trigPulse), 1);
    idle(4);
  endtask

  task automatic t_bounds();
    occThresh = 7'd64; idle(2);
    apply_lines(64'h7FFF_FFFF_FFFF_FFFF, 0, "R10 63 of 64");
    apply_lines(64'hFFFF_FFFF_FFFF_FFFF, 1, "R10 64 of 64");
    occThresh = 7'd1; idle(2);
    apply_lines(64'h0000_0000_8000_0000, 1, "R10 single");
  endtask

  task automatic t_auto_ignores_ext();
    occThresh = 7'd64; idle(2);
    @(negedge clk); extTrig = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R7 ext ignored", int'(trigPulse), 0);
    end
    idle(4);
  endtask

  task automatic t_external();
    modeAuto = 1'b0; occThresh = 7'd1; idle(4);
    @(negedge clk); hitLines = '1;
    repeat (5) begin
      @(negedge clk);
      check("R6 lines ignored", int'(trigPulse), 0);
    end
    extTrig = 1'b1;
    @(negedge clk); check("R6 no early pulse", int'(trigPulse), 0);
    @(negedge clk); check("R6 no pulse at edge 2", int'(trigPulse), 0);
    @(negedge clk); check("R6 pulse at edge 3", int'(trigPulse), 1);
    @(negedge clk); check("R8 ext single cycle", int'(trigPulse), 0);
    @(negedge clk); check("R8 ext held", int'(trigPulse), 0);
    idle(4);
  endtask

  task automatic t_switch();
    modeAuto = 1'b0; occThresh = 7'd3; idle(3);
    @(negedge clk); hitLines = '1;
    repeat (4) @(negedge clk);
    check("R9 ext mode quiet", int'(trigPulse), 0);
    modeAuto = 1'b1;
    @(negedge clk); check("R9 not yet switched", int'(trigPulse), 0);
    @(negedge clk); check("R9 pulse after switch", int'(trigPulse), 1);
    @(negedge clk); check("R9 single after switch", int'(trigPulse), 0);
    idle(4);
  endtask

  initial begin
    t_reset();
    t_count_zero_thresh();
    t_auto_fire();
    t_bounds();
    t_auto_ignores_ext();
    t_external();
    t_switch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule